// File: doc/BRIEF.md
# Platform Reset Generator

This block drives the active-low platform reset and the active-low LAN-controller reset of a board from a handful of power status inputs. The two power-good inputs (the main rails and the processor regulator) are each brought into the system clock domain through a two-flop synchroniser and combined by AND into one effective power-good. While that signal is low the platform reset is held. Once it is high, the block keeps the reset asserted for a minimum time, counted in system clock cycles, before it releases it. A one-cycle software strobe also asserts the platform reset for the same minimum width. A second strobe during an active pulse starts the width again from the beginning.

A slow-clock tick input, already a one-cycle pulse in the system clock domain, measures how long power-good stays low. If power-good stays low across a set number of ticks, the block marks the current reset as a full (cold) reset on `cold_rst_o`. A shorter drop still resets the platform but is not marked as cold. The LAN reset works on its own. It follows the synchronised resume-power-valid flag and is released only after a separate, longer minimum time.

The minimum times are given in milliseconds together with the clock rate in kHz. They are turned into cycle counts when the block is built.

Top module: `plat_rst_gen`

## Requirements
- R1: The effective power-good is the AND of `pwr_ok_i` and `vrm_ok_i`. Each input passes two synchroniser flops, so when either input falls before clock edge 1, `plt_rst_n_o` reads 0 after edge 3 and still reads 1 after edge 2.
- R2: After both power-good inputs rise before edge 1 and stay high, `plt_rst_n_o` stays 0 through edge PLT_CYC+2 and reads 1 after edge PLT_CYC+3, where PLT_CYC = CLK_KHZ*PLT_MS.
- R3: While the synchronised effective power-good is low, `plt_rst_n_o` is 0.
- R4: A one-cycle `sw_rst_req_i` sampled at edge 1 drives `plt_rst_n_o` to 0 after edge 1. The output stays 0 through edge PLT_CYC+1 and reads 1 after edge PLT_CYC+2.
- R5: A further `sw_rst_req_i` while the platform reset is asserted restarts the minimum width. The release then falls PLT_CYC+2 edges after the later strobe.
- R6: When the synchronised power-good is low and the PG_LOW_TICKS-th `rtc_tick_i` pulse of that low period is sampled, `cold_rst_o` reads 1 from that edge on. It stays 1 until `plt_rst_n_o` rises, and is 0 whenever `plt_rst_n_o` is 1.
- R7: A power-good drop that sees fewer than PG_LOW_TICKS ticks still asserts the platform reset but leaves `cold_rst_o` at 0. Ticks are counted only while the synchronised power-good is low. The count restarts from zero at every new low period.
- R8: After `rsm_valid_i` rises before edge 1 and stays high, `lan_rst_n_o` stays 0 through edge LAN_CYC+2 and reads 1 after edge LAN_CYC+3, where LAN_CYC = CLK_KHZ*LAN_MS.
- R9: When `rsm_valid_i` falls before edge 1, `lan_rst_n_o` reads 0 after edge 3. A later rise waits the full LAN_CYC+3 edges again.
- R10: While `rst_n` is low, `plt_rst_n_o` = 0, `lan_rst_n_o` = 0 and `cold_rst_o` = 1.
- R11: `lan_rst_n_o` does not depend on the power-good inputs, the ticks or the software strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| pwr_ok_i | input | 1 | Main rails power-good, asynchronous |
| vrm_ok_i | input | 1 | Processor regulator power-good, asynchronous |
| rsm_valid_i | input | 1 | Resume-well power valid, asynchronous |
| rtc_tick_i | input | 1 | One-cycle slow-clock tick, synchronous to clk |
| sw_rst_req_i | input | 1 | One-cycle software hard-reset request |
| plt_rst_n_o | output | 1 | Platform reset, active low |
| lan_rst_n_o | output | 1 | LAN controller reset, active low |
| cold_rst_o | output | 1 | Current platform reset is a full (cold) reset |

## Verification
The hardest case to reach from the ports is a short power-good drop whose partial tick count must be thrown away. The bench has to place ticks inside two separate low periods, with a release in between, so that a leftover count would finish the cold threshold too early. A similar timing problem comes up with the restart of the software pulse: the second strobe must land at a cycle where a design that ignores it would already have released. The stimulus table places every strobe and tick at a counted edge offset from the last level change. Each check is then made at the exact edge where a correct and a faulty design would differ.

// File: rtl/plat_rst_pkg.sv
package plat_rst_pkg;

  // Minimum width in system clock cycles for a time in milliseconds.
  function automatic int unsigned ms_to_cyc(input int unsigned clk_khz,
                                            input int unsigned ms);
    return clk_khz * ms;
  endfunction

  // Width of a down-counter that must hold the value n.
  function automatic int cnt_w(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg_q[i] <= '0;
        else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/prg_stretch.sv
module prg_stretch #(
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_i,
  output logic hold_o
);
  localparam int CW = plat_rst_pkg::cnt_w(CYC);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt_q;
  logic          hold_q;
  logic          expired;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LOAD;
      hold_q <= 1'b1;
    end else if (force_i) begin
      cnt_q  <= LOAD;
      hold_q <= 1'b1;
    end else if (!expired) begin
      cnt_q  <= cnt_q - 1'b1;
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;

  // Independent run-length of hold since the last force, for the width check.
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (force_i)             run_q <= '0;
    else if (hold_q && run_q < LOAD) run_q <= run_q + 1'b1;
  end

  p_force_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> hold_o);

  // Also guards R8 on the LAN instance.
  p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_o) |-> (run_q >= LOAD));
endmodule

// File: rtl/prg_pg_track.sv
module prg_pg_track #(
  parameter int unsigned TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_s_i,
  input  logic tick_i,
  input  logic hold_i,
  output logic cold_o
);
  localparam int TW = plat_rst_pkg::cnt_w(TICKS);
  localparam logic [TW-1:0] TMAX  = TW'(TICKS);
  localparam logic [TW-1:0] TLAST = TW'(TICKS - 1);

  logic [TW-1:0] tcnt_q;
  logic          cold_q;
  logic          full_evt;

  assign full_evt = !pg_s_i && tick_i && (tcnt_q == TLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tcnt_q <= '0;
    else if (pg_s_i)                   tcnt_q <= '0;
    else if (tick_i && tcnt_q != TMAX) tcnt_q <= tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cold_q <= 1'b1;
    else if (full_evt) cold_q <= 1'b1;
    else if (!hold_i)  cold_q <= 1'b0;
  end

  assign cold_o = cold_q & hold_i;

  p_tick_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt_q == TMAX && !pg_s_i) |=> (tcnt_q == TMAX || $past(pg_s_i) == 1'b0 && pg_s_i == 1'b0));
endmodule

// File: rtl/plat_rst_gen.sv
module plat_rst_gen #(
  parameter int unsigned CLK_KHZ      = 100000,
  parameter int unsigned PLT_MS       = 1,
  parameter int unsigned LAN_MS       = 10,
  parameter int unsigned PG_LOW_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic vrm_ok_i,
  input  logic rsm_valid_i,
  input  logic rtc_tick_i,
  input  logic sw_rst_req_i,
  output logic plt_rst_n_o,
  output logic lan_rst_n_o,
  output logic cold_rst_o
);
  import plat_rst_pkg::*;

  localparam int unsigned PLT_CYC = ms_to_cyc(CLK_KHZ, PLT_MS);
  localparam int unsigned LAN_CYC = ms_to_cyc(CLK_KHZ, LAN_MS);

  logic [2:0] raw_in;
  logic [2:0] syn;
  logic       pg_s;
  logic       rsm_s;
  logic       plt_force;
  logic       plt_hold;
  logic       lan_hold;

  assign raw_in = {rsm_valid_i, vrm_ok_i, pwr_ok_i};

  prg_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (syn)
  );

  assign pg_s      = syn[0] & syn[1];
  assign rsm_s     = syn[2];
  assign plt_force = !pg_s || sw_rst_req_i;

  prg_stretch #(.CYC(PLT_CYC)) u_plt (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_i (plt_force),
    .hold_o  (plt_hold)
  );

  prg_stretch #(.CYC(LAN_CYC)) u_lan (
    .clk     (clk),
    .rst_n   (rst_n),
    .force_i (!rsm_s),
    .hold_o  (lan_hold)
  );

  prg_pg_track #(.TICKS(PG_LOW_TICKS)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .pg_s_i (pg_s),
    .tick_i (rtc_tick_i),
    .hold_i (plt_hold),
    .cold_o (cold_rst_o)
  );

  assign plt_rst_n_o = ~plt_hold;
  assign lan_rst_n_o = ~lan_hold;

  p_sw_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req_i |=> !plt_rst_n_o);

  p_pg_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> !plt_rst_n_o);

  p_lan_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsm_s |=> !lan_rst_n_o);

  p_cold_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cold_rst_o) |-> $past(!pg_s && rtc_tick_i));
endmodule

// File: tb/plat_rst_gen_tb.sv
`timescale 1ns/1ps
module plat_rst_gen_tb;
  localparam int unsigned KHZ = 8;
  localparam int P = 8;    // KHZ * 1 ms
  localparam int L = 80;   // KHZ * 10 ms
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, vrm_ok = 1'b0, rsm_ok = 1'b0, tick = 1'b0, sw = 1'b0;
  logic plt_n, lan_n, cold;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  plat_rst_gen #(.CLK_KHZ(KHZ), .PLT_MS(1), .LAN_MS(10), .PG_LOW_TICKS(3)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok_i     (pwr_ok),
    .vrm_ok_i     (vrm_ok),
    .rsm_valid_i  (rsm_ok),
    .rtc_tick_i   (tick),
    .sw_rst_req_i (sw),
    .plt_rst_n_o  (plt_n),
    .lan_rst_n_o  (lan_n),
    .cold_rst_o   (cold)
  );

  // {req[3:0], pok, vok, rsm, sw, tick, n[7:0], exp_plt_n, exp_lan_n, exp_cold}
  function automatic logic [19:0] mkv(int r, bit pk, bit vk, bit rs, bit s, bit tk,
                                      int n, bit ep, bit el, bit ec);
    return {4'(r), pk, vk, rs, s, tk, 8'(n), ep, el, ec};
  endfunction

  localparam logic [19:0] VECS [NV] = '{
    mkv(1, 1,0,1,0,0, 20,     0,0,1),  // R1 regulator low keeps reset
    mkv(2, 1,1,1,0,0, P+2,    0,0,1),  // R2 one edge before release
    mkv(2, 1,1,1,0,0, 1,      1,0,0),  // R2 release at P+3, R6 cold clears
    mkv(8, 1,1,1,0,0, 51,     1,0,0),  // R8 LAN edge 82 still low
    mkv(8, 1,1,1,0,0, 1,      1,1,0),  // R8 LAN edge 83 release
    mkv(4, 1,1,1,1,0, 1,      0,1,0),  // R4 strobe, R11 LAN unaffected
    mkv(4, 1,1,1,0,0, P,      0,1,0),  // R4 still low at P+1
    mkv(4, 1,1,1,0,0, 1,      1,1,0),  // R4 release at P+2
    mkv(5, 1,1,1,1,0, 5,      0,1,0),  // R5 first strobe
    mkv(5, 1,1,1,1,0, 5,      0,1,0),  // R5 restart: edge 10 from first still low
    mkv(5, 1,1,1,0,0, P+2-5,  1,1,0),  // R5 release P+2 after second
    mkv(1, 0,1,1,0,0, 2,      1,1,0),  // R1 two edges: still released
    mkv(3, 0,1,1,0,0, 1,      0,1,0),  // R3 third edge asserts, R7 not cold
    mkv(7, 0,1,1,0,1, 2,      0,1,0),  // R7 tick one
    mkv(7, 0,1,1,0,1, 2,      0,1,0),  // R7 tick two, not cold
    mkv(7, 1,1,1,0,0, 20,     1,1,0),  // R7 short drop released, never cold
    mkv(3, 0,1,1,0,0, 4,      0,1,0),  // R3 new drop, R11 LAN stays up
    mkv(7, 0,1,1,0,1, 1,      0,1,0),  // R7 count restarted: one tick
    mkv(7, 0,1,1,0,1, 1,      0,1,0),  // R7 two ticks
    mkv(6, 0,1,1,0,1, 1,      0,1,1),  // R6 third tick marks cold
    mkv(6, 1,1,1,0,0, P+2,    0,1,1),  // R6 cold held through reset
    mkv(6, 1,1,1,0,0, 1,      1,1,0),  // R6 cold drops with release
    mkv(9, 1,1,0,0,0, 2,      1,1,0),  // R9 two edges: LAN still up
    mkv(9, 1,1,0,0,0, 1,      1,0,0),  // R9 third edge asserts LAN
    mkv(9, 1,1,1,0,0, L+2,    1,0,0),  // R9 full wait again
    mkv(9, 1,1,1,0,0, 1,      1,1,0)   // R9 release at L+3
  };

  task automatic check(input int r, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: plt_n/lan_n/cold got %b expected %b at %0t", r, got, exp, $time);
    end
  endtask

  // Inputs are set just after a negedge; strobes last one posedge.
  task automatic step(input bit pk, input bit vk, input bit rs, input bit s,
                      input bit tk, input int n);
    pwr_ok = pk; vrm_ok = vk; rsm_ok = rs; sw = s; tick = tk;
    @(negedge clk);
    sw = 1'b0; tick = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(10, {plt_n, lan_n, cold}, 3'b001);            // R10 reset values
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][15], VECS[i][14], VECS[i][13], VECS[i][12], VECS[i][11],
           int'(VECS[i][10:3]));
      check(int'(VECS[i][19:16]), {plt_n, lan_n, cold}, VECS[i][2:0]);
    end

    // R1: regulator power-good alone drops the platform reset.
    step(1, 0, 1, 0, 0, 2);
    check(1, {plt_n, lan_n, cold}, 3'b110);
    step(1, 0, 1, 0, 0, 1);
    check(1, {plt_n, lan_n, cold}, 3'b010);
    step(1, 1, 1, 0, 0, P + 3);
    check(2, {plt_n, lan_n, cold}, 3'b110);

    // R7: ticks while power-good is high are not counted.
    step(1, 1, 1, 0, 1, 1);
    step(1, 1, 1, 0, 1, 1);
    step(1, 1, 1, 0, 1, 1);
    step(0, 1, 1, 0, 0, 4);
    check(7, {plt_n, lan_n, cold}, 3'b010);
    step(0, 1, 1, 0, 1, 1);                             // only first counted tick
    check(7, {plt_n, lan_n, cold}, 3'b010);
    step(1, 1, 1, 0, 0, P + 3);
    check(7, {plt_n, lan_n, cold}, 3'b110);

    // R10: reset in the middle of operation.
    rst_n = 1'b0;
    @(negedge clk);
    check(10, {plt_n, lan_n, cold}, 3'b001);
    rst_n = 1'b1;
    step(1, 1, 1, 0, 0, P + 3);
    check(2, {plt_n, lan_n, cold}, 3'b100);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule